// File: doc/BRIEF.md
# Quality-Ranked Reference Clock Selector

This block chooses one active timing reference out of `N` nominated clock sources (four by default) and drives the select lines of the downstream clock multiplexer. Each source arrives with an availability flag, a quality level taken from the synchronisation status channel, a flag saying whether that channel is in use, a fallback quality level that stands in when the channel is off, and a configured priority. The block reports which source it is tracking and whether it is free-running, locked or in holdover.

In automatic mode the block ranks every available source. It compares effective quality level first, then priority, then source index. In manual mode it follows one configured source. If that source disappears, the block holds over and does not move to another source. The ranking is computed again on every clock. The selected index, the state and the mux select lines are all registered, so each output changes exactly one clock edge after the inputs that cause it, and always on an edge.

Top module: `clk_ref_selector`

## Requirements
- R1: While reset is asserted and right after it, the state is free-run (code 0), the selected index is 0 and all mux select lines are low.
- R2: In automatic mode with at least one source available, the state becomes locked (code 1) and the available source with the largest effective quality level is selected.
- R3: Among available sources with equal effective quality level, the one with the numerically smallest priority value is selected (0 is the best priority).
- R4: Among available sources with equal effective quality level and equal priority, the one with the lowest index is selected.
- R5: A source's effective quality level is its received level when its status-channel enable bit is 1, and its fallback level when that bit is 0.
- R6: Quality level 0 means "no known quality". It ranks below every level from 1 to 15, but an available source with level 0 can still be selected.
- R7: A source whose availability flag is low is never selected while the state is locked.
- R8: In manual mode, if the configured source is available, the state becomes locked on that source regardless of its rank.
- R9: In manual mode, if the configured source is unavailable, the state becomes holdover (code 2) when the block was locked or in holdover, and stays free-run otherwise. The selected index keeps its last value.
- R10: In automatic mode with no source available, the state becomes holdover if it was locked or in holdover, and stays free-run otherwise. The selected index keeps its last value.
- R11: All outputs are registered with one clock of latency. The mux select bus is one-hot on the selected index while locked, and all zero in free-run and holdover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = automatic ranking, 0 = manual |
| manual_src | input | $clog2(N) | Source followed in manual mode |
| src_avail | input | N | Per-source availability flag |
| src_rx_ql | input | N*4 | Per-source received quality level, source i at bits [4i+3:4i] |
| src_ssm_en | input | N | Per-source status-channel enable |
| src_ovr_ql | input | N*4 | Per-source fallback quality level, same packing |
| src_prio | input | N*4 | Per-source priority, same packing, 0 is best |
| sel_src | output | $clog2(N) | Index of the tracked source |
| sel_state | output | 2 | 0 free-run, 1 locked, 2 holdover |
| mux_sel | output | N | One-hot clock mux select, zero unless locked |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. The mux select bus agrees with the state and the index. A locked state never points at a source that was unavailable. Manual mode follows an available configured source. A locked manual source that fails always leads to holdover with the index held. Free-run with nothing available stays free-run. Only the directed scenarios can show that the ranking is right: quality before priority, priority before index, fallback-level substitution and level 0 ranking last all need expected winners computed from chosen input sets.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int QL_W   = 4;
  localparam int PRIO_W = 4;
  localparam int KEY_W  = 1 + QL_W + PRIO_W;

  typedef enum logic [1:0] {
    ST_FREERUN  = 2'd0,
    ST_LOCKED   = 2'd1,
    ST_HOLDOVER = 2'd2
  } csel_state_e;
endpackage

// File: rtl/csel_qual.sv
// Builds a per-source ranking key: {available, effective QL, inverted priority}.
// A larger key is a better candidate.
module csel_qual #(
  parameter int N      = 4,
  parameter int QL_W   = 4,
  parameter int PRIO_W = 4,
  localparam int KW    = 1 + QL_W + PRIO_W
) (
  input  logic [N-1:0]        avail,
  input  logic [N*QL_W-1:0]   rx_ql,
  input  logic [N-1:0]        ssm_en,
  input  logic [N*QL_W-1:0]   ovr_ql,
  input  logic [N*PRIO_W-1:0] prio,
  output logic [N*KW-1:0]     keys
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic [QL_W-1:0] eff_ql;
    assign eff_ql = ssm_en[i] ? rx_ql[i*QL_W +: QL_W] : ovr_ql[i*QL_W +: QL_W];
    assign keys[i*KW +: KW] = {avail[i], eff_ql, ~prio[i*PRIO_W +: PRIO_W]};
  end
endmodule

// File: rtl/csel_rank.sv
// Picks the index of the largest key; strict comparison keeps the lower index on ties.
module csel_rank #(
  parameter int N  = 4,
  parameter int KW = 9,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*KW-1:0] keys,
  output logic [IW-1:0]   best_idx,
  output logic            any_avail
);
  logic [KW-1:0] best_key;

  always_comb begin
    best_key = keys[KW-1:0];
    best_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (keys[i*KW +: KW] > best_key) begin
        best_key = keys[i*KW +: KW];
        best_idx = IW'(i);
      end
    end
    any_avail = best_key[KW-1];
  end
endmodule

// File: rtl/csel_ctrl.sv
// Mode handling and the registered outputs.
module csel_ctrl
  import csel_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_mode,
  input  logic [IW-1:0] manual_src,
  input  logic [N-1:0]  src_avail,
  input  logic [IW-1:0] best_idx,
  input  logic          any_avail,
  output logic [IW-1:0] sel_src,
  output csel_state_e   sel_state,
  output logic [N-1:0]  mux_sel
);
  csel_state_e   state_d;
  logic [IW-1:0] sel_d;
  logic          have_ref;
  logic [IW-1:0] cand;

  always_comb begin
    cand     = auto_mode ? best_idx : manual_src;
    have_ref = auto_mode ? any_avail : src_avail[manual_src];
    sel_d    = sel_src;
    if (have_ref) begin
      state_d = ST_LOCKED;
      sel_d   = cand;
    end else if (sel_state == ST_FREERUN) begin
      state_d = ST_FREERUN;
    end else begin
      state_d = ST_HOLDOVER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_state <= ST_FREERUN;
      sel_src   <= '0;
      mux_sel   <= '0;
    end else begin
      sel_state <= state_d;
      sel_src   <= sel_d;
      mux_sel   <= (state_d == ST_LOCKED) ? (N'(1) << sel_d) : '0;
    end
  end
endmodule

// File: rtl/clk_ref_selector.sv
module clk_ref_selector
  import csel_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_mode,
  input  logic [IW-1:0]       manual_src,
  input  logic [N-1:0]        src_avail,
  input  logic [N*QL_W-1:0]   src_rx_ql,
  input  logic [N-1:0]        src_ssm_en,
  input  logic [N*QL_W-1:0]   src_ovr_ql,
  input  logic [N*PRIO_W-1:0] src_prio,
  output logic [IW-1:0]       sel_src,
  output logic [1:0]          sel_state,
  output logic [N-1:0]        mux_sel
);
  logic [N*KEY_W-1:0] keys;
  logic [IW-1:0]      best_idx;
  logic               any_avail;
  csel_state_e        st;

  csel_qual #(.N(N), .QL_W(QL_W), .PRIO_W(PRIO_W)) u_qual (
    .avail (src_avail),
    .rx_ql (src_rx_ql),
    .ssm_en(src_ssm_en),
    .ovr_ql(src_ovr_ql),
    .prio  (src_prio),
    .keys  (keys)
  );

  csel_rank #(.N(N), .KW(KEY_W)) u_rank (
    .keys     (keys),
    .best_idx (best_idx),
    .any_avail(any_avail)
  );

  csel_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_mode (auto_mode),
    .manual_src(manual_src),
    .src_avail (src_avail),
    .best_idx  (best_idx),
    .any_avail (any_avail),
    .sel_src   (sel_src),
    .sel_state (st),
    .mux_sel   (mux_sel)
  );

  assign sel_state = st;
endmodule

// File: rtl/clk_ref_selector_chk.sv
module clk_ref_selector_chk #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_mode,
  input logic [IW-1:0] manual_src,
  input logic [N-1:0]  src_avail,
  input logic [IW-1:0] sel_src,
  input logic [1:0]    sel_state,
  input logic [N-1:0]  mux_sel
);
  logic [N-1:0] avail_d;
  always_ff @(posedge clk) avail_d <= src_avail;

  p_mux_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state == 2'd1) |-> (mux_sel == (N'(1) << sel_src)));

  p_mux_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state != 2'd1) |-> (mux_sel == '0));

  p_locked_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state == 2'd1) |-> avail_d[sel_src]);

  p_manual_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && src_avail[manual_src]) |=>
      (sel_state == 2'd1 && sel_src == $past(manual_src)));

  p_manual_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state == 2'd1 && !auto_mode && !src_avail[manual_src]) |=>
      (sel_state == 2'd2 && $stable(sel_src)));

  p_auto_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && (|src_avail)) |=> (sel_state == 2'd1));

  p_freerun_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state == 2'd0 && src_avail == '0) |=> (sel_state == 2'd0));
endmodule

bind clk_ref_selector clk_ref_selector_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .auto_mode (auto_mode),
  .manual_src(manual_src),
  .src_avail (src_avail),
  .sel_src   (sel_src),
  .sel_state (sel_state),
  .mux_sel   (mux_sel)
);

// File: tb/clk_ref_selector_tb.sv
module clk_ref_selector_tb;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mode = 1'b1;
  logic [IW-1:0] manual_src = '0;
  logic [N-1:0] avail = '0;
  logic [N-1:0] ssm = '0;
  logic [3:0] rx [N];
  logic [3:0] ovr [N];
  logic [3:0] pr [N];
  logic [N*4-1:0] rx_bus, ovr_bus, pr_bus;
  logic [IW-1:0] sel_src;
  logic [1:0] sel_state;
  logic [N-1:0] mux_sel;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rx_bus[i*4 +: 4]  = rx[i];
      ovr_bus[i*4 +: 4] = ovr[i];
      pr_bus[i*4 +: 4]  = pr[i];
    end
  end

  clk_ref_selector #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .manual_src(manual_src),
    .src_avail(avail), .src_rx_ql(rx_bus), .src_ssm_en(ssm), .src_ovr_ql(ovr_bus),
    .src_prio(pr_bus), .sel_src(sel_src), .sel_state(sel_state), .mux_sel(mux_sel)
  );

  task automatic expect_out(string req, logic [1:0] st, logic [IW-1:0] idx);
    logic [N-1:0] m;
    m = (st == 2'd1) ? (N'(1) << idx) : '0;
    n_chk++;
    if (sel_state !== st || sel_src !== idx || mux_sel !== m) begin
      n_fail++;
      $display("FAIL %s: got state=%0d sel=%0d mux=%b, expected state=%0d sel=%0d mux=%b",
               req, sel_state, sel_src, mux_sel, st, idx, m);
    end
  endtask

  task automatic set_src(int i, bit a, bit s, logic [3:0] r, logic [3:0] o, logic [3:0] p);
    avail[i] = a; ssm[i] = s; rx[i] = r; ovr[i] = o; pr[i] = p;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) set_src(i, 0, 1, 4'd0, 4'd0, 4'd0);
    auto_mode = 1'b1;
    manual_src = '0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    expect_out("R1 after reset", 2'd0, 2'd0);
    step();
    expect_out("R1 idle free-run", 2'd0, 2'd0);
  endtask

  task automatic t_quality();
    do_reset();
    set_src(0, 1, 1, 4'd3, 4'd0, 4'd0);
    set_src(1, 1, 1, 4'd7, 4'd0, 4'd9);
    set_src(2, 1, 1, 4'd5, 4'd0, 4'd0);
    set_src(3, 1, 1, 4'd2, 4'd0, 4'd0);
    #1 expect_out("R11 no change before edge", 2'd0, 2'd0);
    step();
    expect_out("R2 highest QL wins over better priority", 2'd1, 2'd1);
    set_src(3, 1, 1, 4'd12, 4'd0, 4'd15);
    step();
    expect_out("R2 new best QL", 2'd1, 2'd3);
  endtask

  task automatic t_priority();
    do_reset();
    set_src(0, 1, 1, 4'd6, 4'd0, 4'd5);
    set_src(1, 1, 1, 4'd6, 4'd0, 4'd3);
    set_src(2, 1, 1, 4'd6, 4'd0, 4'd2);
    set_src(3, 1, 1, 4'd6, 4'd0, 4'd7);
    step();
    expect_out("R3 lowest priority value wins", 2'd1, 2'd2);
    pr[1] = 4'd2;
    step();
    expect_out("R4 equal QL and prio lower index", 2'd1, 2'd1);
    for (int i = 0; i < N; i++) pr[i] = 4'd4;
    step();
    expect_out("R4 all equal picks index 0", 2'd1, 2'd0);
    avail[0] = 1'b0;
    step();
    expect_out("R7 unavailable source skipped", 2'd1, 2'd1);
  endtask

  task automatic t_ssm();
    do_reset();
    set_src(0, 1, 0, 4'd15, 4'd1, 4'd0);
    set_src(1, 1, 1, 4'd4, 4'd14, 4'd0);
    step();
    expect_out("R5 fallback QL used when channel off, rx when on", 2'd1, 2'd1);
    ovr[0] = 4'd12;
    step();
    expect_out("R5 raised fallback QL wins", 2'd1, 2'd0);
  endtask

  task automatic t_ql_none();
    do_reset();
    set_src(3, 1, 1, 4'd0, 4'd0, 4'd0);
    step();
    expect_out("R6 lone QL-none source selected", 2'd1, 2'd3);
    set_src(2, 1, 0, 4'd0, 4'd1, 4'd15);
    step();
    expect_out("R6 QL-none ranks below QL 1", 2'd1, 2'd2);
  endtask

  task automatic t_auto_none();
    do_reset();
    set_src(2, 1, 1, 4'd8, 4'd0, 4'd0);
    step();
    expect_out("R2 lock before loss", 2'd1, 2'd2);
    avail = '0;
    step();
    expect_out("R10 holdover after loss", 2'd2, 2'd2);
    step();
    expect_out("R10 holdover persists", 2'd2, 2'd2);
    avail[2] = 1'b1;
    step();
    expect_out("R2 relock from holdover", 2'd1, 2'd2);
    do_reset();
    step();
    expect_out("R10 free-run when never locked", 2'd0, 2'd0);
  endtask

  task automatic t_manual();
    do_reset();
    auto_mode = 1'b0;
    manual_src = 2'd1;
    set_src(0, 1, 1, 4'd15, 4'd0, 4'd0);
    set_src(1, 0, 1, 4'd1, 4'd0, 4'd15);
    step();
    expect_out("R9 manual source down, never locked", 2'd0, 2'd0);
    avail[1] = 1'b1;
    step();
    expect_out("R8 manual follows worse source", 2'd1, 2'd1);
    avail[1] = 1'b0;
    step();
    expect_out("R9 holdover not switch", 2'd2, 2'd1);
    manual_src = 2'd0;
    step();
    expect_out("R8 manual moves to new source", 2'd1, 2'd0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin rx[i] = 0; ovr[i] = 0; pr[i] = 0; end
    t_reset();
    t_quality();
    t_priority();
    t_ssm();
    t_ql_none();
    t_auto_none();
    t_manual();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule